// File: doc/BRIEF.md
# Standby Power Mode Controller

This block sequences the deepest low-power state of a small microcontroller. It starts from a running chip. When the CPU signals that it is executing a sleep operation and the standby-select control bit is set, the block removes the CPU clock, the peripheral clock and the oscillator enable. On entry it pulses a reset to the peripheral groups that do not keep state through standby, which are the serial, converter, CAN and I/O-port logic. All other state is kept. While the chip is stopped, a control bit decides whether the external address bus and bus strobes float or hold their last driven values.

Three kinds of event wake the chip: a non-maskable interrupt, an external interrupt line that passes qualification, or a hardware reset input. When any of them arrives, the oscillator is enabled first. A settling countdown is then loaded; a 3-bit select field sets its length. Clocks return only when the countdown ends. In that same cycle the block emits either a wake strobe, which carries a 3-bit code for the winning interrupt, or a reset strobe.

A separate force-standby input stops the chip immediately, whatever state it is in. When that input is released, the chip restarts along the same path as a hardware reset. The block also holds a module-stop register. Only the CPU bus master may write it.

Top module: `standby_seq`

## Requirements
- R1: A one-cycle `sleep_req` with `ctl_standby_sel`=1 in the running state makes `cpu_clk_en`, `per_clk_en` and `osc_en` all 0 from the next cycle.
- R2: A `sleep_req` with `ctl_standby_sel`=0 has no effect: clocks and oscillator stay enabled.
- R3: In standby, a qualified wake sets `osc_en`=1 in the next cycle while both clock enables stay 0. The clock enables and a one-cycle `wake_strobe` rise together exactly 2^(3+`ctl_settle_sel`) cycles later (8 for code 0 up to 1024 for code 7).
- R4: IRQ line i wakes the chip only when `irq_en[i]`=1, `irq_mask[i]`=0 and `irq_dma[i]`=0. In any other combination it is ignored and `osc_en` stays 0.
- R5: `wake_code` is 7 when `nmi_req` wins. NMI beats every IRQ line in the same cycle. Among IRQ lines, the lowest index i wins and its code is i.
- R6: While clocks are stopped, `bus_hiz`=1 and `bus_hold`=0 if `ctl_bus_float`=1; otherwise `bus_hiz`=0 and `bus_hold`=1. Both are 0 while running.
- R7: `volatile_rst` pulses for exactly the first cycle of each standby entry and at no other time.
- R8: `hw_reset_in` starts the settling countdown in any state and takes priority over interrupt wakes. At the end of the countdown the block issues `rst_strobe` and no `wake_strobe`.
- R9: `standby_force`=1 forces standby from the next cycle, and interrupts do not wake the chip while it is held. Its release starts the countdown and ends with `rst_strobe`.
- R10: A write with `modstop_wr`=1 and `modstop_wr_dma`=0 loads `modstop_q` on the next cycle. A write with `modstop_wr_dma`=1 leaves `modstop_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock; also paces the settling count |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sleep_req | input | 1 | CPU sleep operation, one-cycle pulse |
| ctl_standby_sel | input | 1 | Sleep enters standby when 1 |
| ctl_bus_float | input | 1 | Bus floats (1) or holds (0) while stopped |
| ctl_settle_sel | input | SEL_W | Settling length code |
| nmi_req | input | 1 | Non-maskable interrupt request |
| irq_req | input | N_IRQ | External interrupt requests |
| irq_en | input | N_IRQ | Per-line enable |
| irq_mask | input | N_IRQ | Per-line CPU-side mask |
| irq_dma | input | N_IRQ | Per-line DMA-trigger designation |
| hw_reset_in | input | 1 | Hardware reset request |
| standby_force | input | 1 | Force-standby input |
| modstop_wr | input | 1 | Module-stop register write |
| modstop_wr_dma | input | 1 | Write comes from the DMA master |
| modstop_wr_data | input | MSTP_W | Module-stop write data |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| bus_hiz | output | 1 | External bus high-impedance |
| bus_hold | output | 1 | External bus holds last value |
| volatile_rst | output | 1 | Reset pulse for non-retaining peripherals |
| wake_strobe | output | 1 | Interrupt exception start |
| wake_code | output | CODE_W | Winning source code, valid with wake_strobe |
| rst_strobe | output | 1 | Reset-path restart strobe |
| modstop_q | output | MSTP_W | Module-stop register value |

## Verification
The assertions assume that `sleep_req` reaches the block only as the CPU's single-cycle pulse. They assume the settle select and the bus-float bit do not change between a wake trigger and its strobe. They also take the reset input to be a short pulse, because a held reset restarts the countdown on every cycle. The stimulus keeps to all three conditions: it raises each request line for exactly one cycle, and it writes the control fields only while the chip is running or fully stopped.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
   typedef enum logic [1:0] {
      ST_RUN    = 2'd0,
      ST_STOP   = 2'd1,
      ST_SETTLE = 2'd2
   } sbs_state_e;

   typedef enum logic {
      SRC_IRQ   = 1'b0,
      SRC_RESET = 1'b1
   } sbs_src_e;
endpackage

// File: rtl/sbs_wake_qual.sv
module sbs_wake_qual #(
   parameter int N_IRQ  = 6,
   parameter int CODE_W = 3
) (
   input  logic              nmi_req,
   input  logic [N_IRQ-1:0]  irq_req,
   input  logic [N_IRQ-1:0]  irq_en,
   input  logic [N_IRQ-1:0]  irq_mask,
   input  logic [N_IRQ-1:0]  irq_dma,
   output logic              wake_any,
   output logic [CODE_W-1:0] wake_code
);
   localparam logic [CODE_W-1:0] NMI_CODE = {CODE_W{1'b1}};

   if (N_IRQ < 1) begin : g_bad_nirq
      $error("sbs_wake_qual: N_IRQ must be at least 1");
   end
   if (N_IRQ >= (1 << CODE_W)) begin : g_bad_code
      $error("sbs_wake_qual: CODE_W too narrow for N_IRQ plus the NMI code");
   end

   logic [N_IRQ-1:0] qual;

   for (genvar i = 0; i < N_IRQ; i++) begin : g_line
      assign qual[i] = irq_req[i] & irq_en[i] & ~irq_mask[i] & ~irq_dma[i];
   end

   logic              irq_hit;
   logic [CODE_W-1:0] irq_code;

   always_comb begin
      irq_hit  = 1'b0;
      irq_code = '0;
      for (int i = N_IRQ - 1; i >= 0; i--) begin
         if (qual[i]) begin
            irq_hit  = 1'b1;
            irq_code = CODE_W'(i);
         end
      end
   end

   assign wake_any  = nmi_req | irq_hit;
   assign wake_code = nmi_req ? NMI_CODE : irq_code;
endmodule

// File: rtl/sbs_settle_tmr.sv
module sbs_settle_tmr #(
   parameter int SEL_W     = 3,
   parameter int BASE_LOG2 = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [SEL_W-1:0] sel,
   output logic             done
);
   localparam int CNT_W = BASE_LOG2 + (1 << SEL_W);

   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("sbs_settle_tmr: SEL_W out of range");
   end
   if (BASE_LOG2 < 1) begin : g_bad_base
      $error("sbs_settle_tmr: BASE_LOG2 must be positive");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_val;

   assign load_val = CNT_W'(1) << (32'(BASE_LOG2) + 32'(sel));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign done = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/sbs_modstop_reg.sv
module sbs_modstop_reg #(
   parameter int                W       = 16,
   parameter logic [W-1:0]      RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic         wr_dma,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("sbs_modstop_reg: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= RST_VAL;
      end else if (wr && !wr_dma) begin
         q <= wr_data;
      end
   end
endmodule

// File: rtl/standby_seq.sv
module standby_seq
   import sbs_pkg::*;
#(
   parameter int                N_IRQ     = 6,
   parameter int                SEL_W     = 3,
   parameter int                BASE_LOG2 = 3,
   parameter int                CODE_W    = 3,
   parameter int                MSTP_W    = 16,
   parameter logic [MSTP_W-1:0] MSTP_RST  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep_req,
   input  logic              ctl_standby_sel,
   input  logic              ctl_bus_float,
   input  logic [SEL_W-1:0]  ctl_settle_sel,
   input  logic              nmi_req,
   input  logic [N_IRQ-1:0]  irq_req,
   input  logic [N_IRQ-1:0]  irq_en,
   input  logic [N_IRQ-1:0]  irq_mask,
   input  logic [N_IRQ-1:0]  irq_dma,
   input  logic              hw_reset_in,
   input  logic              standby_force,
   input  logic              modstop_wr,
   input  logic              modstop_wr_dma,
   input  logic [MSTP_W-1:0] modstop_wr_data,
   output logic              cpu_clk_en,
   output logic              per_clk_en,
   output logic              osc_en,
   output logic              bus_hiz,
   output logic              bus_hold,
   output logic              volatile_rst,
   output logic              wake_strobe,
   output logic [CODE_W-1:0] wake_code,
   output logic              rst_strobe,
   output logic [MSTP_W-1:0] modstop_q
);
   sbs_state_e        st_q, st_nx;
   sbs_src_e          src_q, src_nx;
   logic [CODE_W-1:0] code_q, code_nx;
   logic              hold_q, hold_nx;
   logic              wstb_nx, rstb_nx, vrst_nx;
   logic              tmr_load, tmr_done;
   logic              wq_any;
   logic [CODE_W-1:0] wq_code;

   sbs_wake_qual #(.N_IRQ(N_IRQ), .CODE_W(CODE_W)) u_qual (
      .nmi_req  (nmi_req),
      .irq_req  (irq_req),
      .irq_en   (irq_en),
      .irq_mask (irq_mask),
      .irq_dma  (irq_dma),
      .wake_any (wq_any),
      .wake_code(wq_code)
   );

   sbs_settle_tmr #(.SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2)) u_tmr (
      .clk  (clk),
      .rst_n(rst_n),
      .load (tmr_load),
      .sel  (ctl_settle_sel),
      .done (tmr_done)
   );

   sbs_modstop_reg #(.W(MSTP_W), .RST_VAL(MSTP_RST)) u_mstop (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (modstop_wr),
      .wr_dma (modstop_wr_dma),
      .wr_data(modstop_wr_data),
      .q      (modstop_q)
   );

   always_comb begin
      st_nx    = st_q;
      src_nx   = src_q;
      code_nx  = code_q;
      hold_nx  = hold_q;
      tmr_load = 1'b0;
      wstb_nx  = 1'b0;
      rstb_nx  = 1'b0;
      vrst_nx  = 1'b0;
      if (standby_force) begin
         st_nx   = ST_STOP;
         hold_nx = 1'b1;
         vrst_nx = (st_q != ST_STOP);
      end else begin
         unique case (st_q)
            ST_RUN: begin
               if (hw_reset_in) begin
                  st_nx    = ST_SETTLE;
                  src_nx   = SRC_RESET;
                  tmr_load = 1'b1;
               end else if (sleep_req && ctl_standby_sel) begin
                  st_nx   = ST_STOP;
                  vrst_nx = 1'b1;
               end
            end
            ST_STOP: begin
               if (hold_q || hw_reset_in) begin
                  st_nx    = ST_SETTLE;
                  src_nx   = SRC_RESET;
                  hold_nx  = 1'b0;
                  tmr_load = 1'b1;
               end else if (wq_any) begin
                  st_nx    = ST_SETTLE;
                  src_nx   = SRC_IRQ;
                  code_nx  = wq_code;
                  tmr_load = 1'b1;
               end
            end
            ST_SETTLE: begin
               if (hw_reset_in) begin
                  src_nx   = SRC_RESET;
                  tmr_load = 1'b1;
               end else if (tmr_done) begin
                  st_nx   = ST_RUN;
                  wstb_nx = (src_q == SRC_IRQ);
                  rstb_nx = (src_q == SRC_RESET);
               end
            end
            default: st_nx = ST_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= ST_RUN;
         src_q        <= SRC_IRQ;
         code_q       <= '0;
         hold_q       <= 1'b0;
         wake_strobe  <= 1'b0;
         rst_strobe   <= 1'b0;
         volatile_rst <= 1'b0;
      end else begin
         st_q         <= st_nx;
         src_q        <= src_nx;
         code_q       <= code_nx;
         hold_q       <= hold_nx;
         wake_strobe  <= wstb_nx;
         rst_strobe   <= rstb_nx;
         volatile_rst <= vrst_nx;
      end
   end

   assign cpu_clk_en = (st_q == ST_RUN);
   assign per_clk_en = (st_q == ST_RUN);
   assign osc_en     = (st_q != ST_STOP);
   assign bus_hiz    = (st_q != ST_RUN) &&  ctl_bus_float;
   assign bus_hold   = (st_q != ST_RUN) && !ctl_bus_float;
   assign wake_code  = wake_strobe ? code_q : '0;
endmodule

// File: rtl/standby_seq_chk.sv
module standby_seq_chk #(
   parameter int N_IRQ  = 6,
   parameter int MSTP_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sleep_req,
   input logic              ctl_standby_sel,
   input logic              nmi_req,
   input logic [N_IRQ-1:0]  irq_req,
   input logic [N_IRQ-1:0]  irq_en,
   input logic [N_IRQ-1:0]  irq_mask,
   input logic [N_IRQ-1:0]  irq_dma,
   input logic              hw_reset_in,
   input logic              standby_force,
   input logic              modstop_wr,
   input logic              modstop_wr_dma,
   input logic [MSTP_W-1:0] modstop_q,
   input logic              cpu_clk_en,
   input logic              per_clk_en,
   input logic              osc_en,
   input logic              bus_hiz,
   input logic              bus_hold,
   input logic              volatile_rst,
   input logic              wake_strobe,
   input logic              rst_strobe
);
   assert_sleep_stops_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_clk_en && sleep_req && ctl_standby_sel && !hw_reset_in)
      |=> (!osc_en && !cpu_clk_en && !per_clk_en));

   assert_no_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_clk_en && sleep_req && !ctl_standby_sel && !hw_reset_in && !standby_force)
      |=> cpu_clk_en);

   assert_strobe_with_clocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wake_strobe |-> (cpu_clk_en && !$past(cpu_clk_en)));

   assert_unqualified_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc_en && !nmi_req && ((irq_req & irq_en & ~irq_mask & ~irq_dma) == '0)
       && !hw_reset_in && !standby_force && !$past(standby_force))
      |=> !osc_en);

   assert_bus_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_clk_en |-> $onehot({bus_hiz, bus_hold}));

   assert_vrst_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      volatile_rst |-> (!osc_en && !$past(volatile_rst)));

   assert_strobes_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wake_strobe && rst_strobe));

   assert_force_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
      standby_force |=> !osc_en);

   assert_dma_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (modstop_wr && modstop_wr_dma) |=> $stable(modstop_q));
endmodule

bind standby_seq standby_seq_chk #(.N_IRQ(N_IRQ), .MSTP_W(MSTP_W)) u_chk (.*);

// File: tb/sim_standby_seq.sv
`timescale 1ns/1ps
module sim_standby_seq;
   localparam int N_IRQ = 6;
   localparam int MSTP_W = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              sleep_req = 1'b0, ctl_standby_sel = 1'b0, ctl_bus_float = 1'b0;
   logic [2:0]        ctl_settle_sel = '0;
   logic              nmi_req = 1'b0;
   logic [N_IRQ-1:0]  irq_req = '0, irq_en = '0, irq_mask = '0, irq_dma = '0;
   logic              hw_reset_in = 1'b0, standby_force = 1'b0;
   logic              modstop_wr = 1'b0, modstop_wr_dma = 1'b0;
   logic [MSTP_W-1:0] modstop_wr_data = '0;
   logic              cpu_clk_en, per_clk_en, osc_en, bus_hiz, bus_hold;
   logic              volatile_rst, wake_strobe, rst_strobe;
   logic [2:0]        wake_code;
   logic [MSTP_W-1:0] modstop_q;

   standby_seq u0 (.*);

   always #5 clk = ~clk;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit finished = 1'b0;

   typedef struct {
      bit         is_rst;
      logic [2:0] code;
      int         at;
      string      req;
   } evt_t;
   evt_t exp_q[$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Scoreboard driver side: trigger is sampled at the next posedge, then the
   // countdown takes 8<<sel cycles.
   task automatic push_evt(bit is_rst, logic [2:0] code, int sel, string req);
      evt_t e;
      e.is_rst = is_rst;
      e.code   = code;
      e.at     = cyc + 1 + (8 << sel);
      e.req    = req;
      exp_q.push_back(e);
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   // Scoreboard monitor side
   always @(negedge clk) begin
      if (rst_n && (wake_strobe || rst_strobe)) begin
         if (exp_q.size() == 0) begin
            chk("R3", "unexpected strobe", 1, 0);
         end else begin
            evt_t e;
            e = exp_q.pop_front();
            chk(e.req, "reset strobe kind", int'(rst_strobe), int'(e.is_rst));
            chk(e.req, "wake strobe kind", int'(wake_strobe), int'(!e.is_rst));
            chk(e.req, "strobe cycle", cyc, e.at);
            chk(e.req, "clock back with strobe", int'(cpu_clk_en), 1);
            if (!e.is_rst) chk(e.req, "wake code", int'(wake_code), int'(e.code));
         end
      end
   end

   task automatic sleep_pulse();
      sleep_req = 1'b1;
      step(1);
      sleep_req = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      chk("R3", "watchdog expired", 1, 0);
      finish_run();
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // reset state
      chk("R1", "reset cpu_clk_en", int'(cpu_clk_en), 1);
      chk("R1", "reset osc_en", int'(osc_en), 1);
      chk("R6", "reset bus_hiz", int'(bus_hiz), 0);
      chk("R6", "reset bus_hold", int'(bus_hold), 0);
      chk("R10", "reset modstop_q", int'(modstop_q), 0);

      // R2: sleep without standby select
      sleep_pulse();
      chk("R2", "cpu clock after plain sleep", int'(cpu_clk_en), 1);
      chk("R2", "osc after plain sleep", int'(osc_en), 1);
      step(2);
      chk("R2", "per clock later", int'(per_clk_en), 1);

      // R1, R6, R7: standby entry with floating bus
      ctl_standby_sel = 1'b1;
      ctl_bus_float = 1'b1;
      ctl_settle_sel = 3'd0;
      sleep_pulse();
      chk("R1", "cpu_clk_en in standby", int'(cpu_clk_en), 0);
      chk("R1", "per_clk_en in standby", int'(per_clk_en), 0);
      chk("R1", "osc_en in standby", int'(osc_en), 0);
      chk("R7", "volatile_rst first cycle", int'(volatile_rst), 1);
      chk("R6", "bus_hiz floating", int'(bus_hiz), 1);
      chk("R6", "bus_hold floating", int'(bus_hold), 0);
      step(1);
      chk("R7", "volatile_rst second cycle", int'(volatile_rst), 0);

      // R4: unqualified requests ignored
      irq_req = 6'b000100;
      step(3);
      chk("R4", "disabled line ignored", int'(osc_en), 0);
      irq_en = '1;
      irq_mask = 6'b000100;
      step(3);
      chk("R4", "masked line ignored", int'(osc_en), 0);
      irq_mask = '0;
      irq_dma = 6'b000100;
      step(3);
      chk("R4", "dma-designated line ignored", int'(osc_en), 0);
      chk("R4", "cpu clock still off", int'(cpu_clk_en), 0);
      irq_req = '0;
      irq_dma = '0;
      step(1);

      // R3, R5: lowest qualified IRQ wins
      irq_req = 6'b001010;
      push_evt(1'b0, 3'd1, 0, "R5");
      step(1);
      irq_req = '0;
      chk("R3", "osc on during settle", int'(osc_en), 1);
      chk("R3", "cpu clock off during settle", int'(cpu_clk_en), 0);
      chk("R7", "no volatile_rst on wake", int'(volatile_rst), 0);
      step(12);
      chk("R3", "running after wake", int'(cpu_clk_en), 1);

      // R6, R5, R3: held bus, NMI beats IRQ0, longer settle
      ctl_bus_float = 1'b0;
      ctl_settle_sel = 3'd2;
      sleep_pulse();
      chk("R6", "bus_hold holding", int'(bus_hold), 1);
      chk("R6", "bus_hiz holding", int'(bus_hiz), 0);
      chk("R7", "volatile_rst second entry", int'(volatile_rst), 1);
      step(2);
      nmi_req = 1'b1;
      irq_req = 6'b000001;
      push_evt(1'b0, 3'd7, 2, "R5");
      step(1);
      nmi_req = 1'b0;
      irq_req = '0;
      step(40);

      // R8: reset input beats interrupt, longest settle
      ctl_settle_sel = 3'd7;
      sleep_pulse();
      step(2);
      hw_reset_in = 1'b1;
      irq_req = 6'b000001;
      push_evt(1'b1, 3'd0, 7, "R8");
      step(1);
      hw_reset_in = 1'b0;
      irq_req = '0;
      chk("R8", "osc on during reset settle", int'(osc_en), 1);
      step(1030);
      chk("R8", "running after reset", int'(cpu_clk_en), 1);

      // R9: force-standby from running
      ctl_settle_sel = 3'd1;
      standby_force = 1'b1;
      step(1);
      chk("R9", "forced stop osc", int'(osc_en), 0);
      chk("R9", "forced stop cpu clock", int'(cpu_clk_en), 0);
      chk("R7", "volatile_rst on forced entry", int'(volatile_rst), 1);
      irq_req = 6'b000010;
      step(4);
      chk("R9", "irq ignored while forced", int'(osc_en), 0);
      irq_req = '0;
      standby_force = 1'b0;
      push_evt(1'b1, 3'd0, 1, "R9");
      step(20);
      chk("R9", "running after release", int'(cpu_clk_en), 1);

      // R10: module-stop write masters
      modstop_wr = 1'b1;
      modstop_wr_data = 16'hA5C3;
      step(1);
      modstop_wr = 1'b0;
      chk("R10", "cpu write loads", int'(modstop_q), 16'hA5C3);
      modstop_wr = 1'b1;
      modstop_wr_dma = 1'b1;
      modstop_wr_data = 16'h1234;
      step(1);
      modstop_wr = 1'b0;
      modstop_wr_dma = 1'b0;
      step(1);
      chk("R10", "dma write ignored", int'(modstop_q), 16'hA5C3);

      step(5);
      chk("R3", "all expected strobes seen", exp_q.size(), 0);
      finish_run();
   end
endmodule